// File: doc/BRIEF.md
# RMA Secret Erasure Sequencer

When the return-for-repair lifecycle bit becomes programmed, this block wipes the device's secrets with no software involved. It erases three storage regions, one after another, through a generic erase request and acknowledge interface. The regions are the trusted-execution keyslots, the material that wraps the user-data encryption key, and the stored attestation key blobs. After the last acknowledge arrives, it asks the fuse programming logic to burn a sticky wipe-done fuse. Once that fuse reads back as set, the block raises the wipe-complete qualifier that the debug gate needs before it will honour authentication in this lifecycle state.

Because the fuse is sticky, the work is idempotent. If the wipe-done fuse already reads 1 at reset, the sequencer reports done straight away and touches no storage. If a reset interrupts the sequence before the fuse is burnt, the whole wipe runs again from the first region. If any region reports an error, the block locks into a fault state and the qualifier stays low. No path leads to wipe-complete while protected data could still exist.

The erase request is a valid/ready channel. Once `erase_req_valid` is raised, it stays high and `erase_req_region` stays unchanged until a cycle with `erase_req_ready` high accepts the request. The responder returns exactly one acknowledge beat (`erase_ack_valid`, with `erase_ack_err` qualifying it) for each accepted request. It does so only after acceptance, and the block always takes that beat.

Top module: `rma_wipe_seq`

## Requirements
- R1: With the wipe-done fuse reading 0, the first cycle after reset in which the lifecycle bit reads 1 starts erasure by itself. The first request then carries region code 0.
- R2: Regions are requested strictly in the order code 0 (keyslots), code 1 (key-wrapping material), code 2 (attestation blobs). The next request is not raised until the acknowledge for the previous one has been received.
- R3: While a request is pending and not accepted, `erase_req_valid` stays high and `erase_req_region` stays unchanged.
- R4: After the last region acknowledges without error, `fuse_prog_req` rises and stays high until `fuse_prog_ack`. In the following cycle `done` goes high and stays high until reset.
- R5: If the wipe-done fuse reads 1 at reset, the block reaches done with wipe-complete high. It raises no erase request and no fuse request.
- R6: `wipe_complete` is high only when the block is done and the wipe-done fuse reads 1. It is never high while busy or faulted.
- R7: An acknowledge with the error flag set moves the block into a sticky fault state. In that state `fault` is high, `wipe_complete` is low, and no further request is raised.
- R8: A reset taken mid-sequence while the fuse is still clear makes the next run start again from region code 0.
- R9: While both the lifecycle bit and the fuse read 0, the block stays idle with every output low.
- R10: `busy` is high from the first erase request until the fuse acknowledge, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rma_lc_i | input | 1 | Return-for-repair lifecycle bit is programmed |
| wipe_fuse_i | input | 1 | Wipe-done fuse readback |
| erase_req_valid | output | 1 | Erase request valid |
| erase_req_ready | input | 1 | Erase request accepted by storage |
| erase_req_region | output | 2 | Region code of the pending request |
| erase_ack_valid | input | 1 | Erase acknowledge beat |
| erase_ack_err | input | 1 | Acknowledge reports an erase failure |
| fuse_prog_req | output | 1 | Request to burn the wipe-done fuse |
| fuse_prog_ack | input | 1 | Fuse programming finished |
| busy | output | 1 | Erasure or fuse programming in progress |
| done | output | 1 | Sequence finished |
| fault | output | 1 | An erase error was reported |
| wipe_complete | output | 1 | Qualifier for the debug gate |

## Verification
The assertions rely on four things about the inputs. An acknowledge beat arrives only for a request that has been accepted and is awaiting its response. `fuse_prog_ack` is driven only while the fuse request is high. The fuse readback turns to 1 only after that acknowledge. The lifecycle bit does not drop during a run. The stimulus draws random ready stalls and acknowledge latencies from a fixed-seed generator. It drives `erase_ack_valid` only after seeing a request accepted, answers the fuse request only while it is raised, and models the fuse as a bit that the bench sets on acknowledge. Directed cases add an error on a random region, a pre-burnt fuse, and a reset between regions.

// File: rtl/rma_wipe_pkg.sv
package rma_wipe_pkg;
  typedef enum logic [2:0] {
    WS_IDLE  = 3'd0,
    WS_ERASE = 3'd1,
    WS_FUSE  = 3'd2,
    WS_DONE  = 3'd3,
    WS_FAULT = 3'd4
  } wipe_state_e;

  typedef enum logic [1:0] {
    IS_IDLE = 2'd0,
    IS_REQ  = 2'd1,
    IS_WAIT = 2'd2
  } issue_state_e;
endpackage

// File: rtl/rma_region_ctr.sv
module rma_region_ctr #(
  parameter int N_REGIONS = 3,
  parameter int REG_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [REG_W-1:0] idx_o,
  output logic             last_o
);
  localparam logic [REG_W-1:0] LAST_IDX = REG_W'(N_REGIONS - 1);

  logic [REG_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (clr_i) begin
      idx_q <= '0;
    end else if (inc_i && idx_q != LAST_IDX) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == LAST_IDX);

  // R2: the region index never walks past the last region
  p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);

  // R2: the index advances by exactly one on an increment
  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && idx_q != LAST_IDX) |=> idx_q == $past(idx_q) + 1'b1);
endmodule

// File: rtl/rma_erase_issuer.sv
module rma_erase_issuer
  import rma_wipe_pkg::*;
#(
  parameter int REG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [REG_W-1:0] region_i,
  output logic             req_valid_o,
  output logic [REG_W-1:0] req_region_o,
  input  logic             req_ready_i,
  input  logic             ack_valid_i,
  input  logic             ack_err_i,
  output logic             ok_o,
  output logic             err_o
);
  issue_state_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= IS_IDLE;
    end else begin
      unique case (st_q)
        IS_IDLE: if (start_i) st_q <= IS_REQ;
        IS_REQ:  if (req_ready_i) st_q <= IS_WAIT;
        IS_WAIT: if (ack_valid_i) st_q <= start_i ? IS_REQ : IS_IDLE;
        default: st_q <= IS_IDLE;
      endcase
    end
  end

  assign req_valid_o  = (st_q == IS_REQ);
  assign req_region_o = region_i;
  assign ok_o         = (st_q == IS_WAIT) && ack_valid_i && !ack_err_i;
  assign err_o        = (st_q == IS_WAIT) && ack_valid_i && ack_err_i;

  // R3: a stalled request keeps valid and its region code
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_region_o)));

  // R2: an accepted request is followed by a gap with valid low
  p_one_at_a_time_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_ready_i) |=> !req_valid_o);
endmodule

// File: rtl/rma_wipe_ctrl.sv
module rma_wipe_ctrl
  import rma_wipe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rma_lc_i,
  input  logic wipe_fuse_i,
  input  logic ok_i,
  input  logic err_i,
  input  logic last_i,
  input  logic fuse_ack_i,
  output logic start_o,
  output logic clr_o,
  output logic inc_o,
  output logic fuse_req_o,
  output logic busy_o,
  output logic done_o,
  output logic fault_o,
  output logic complete_o
);
  wipe_state_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    start_o = 1'b0;
    clr_o   = 1'b0;
    inc_o   = 1'b0;
    unique case (st_q)
      WS_IDLE: begin
        if (wipe_fuse_i) begin
          st_d = WS_DONE;
        end else if (rma_lc_i) begin
          st_d    = WS_ERASE;
          start_o = 1'b1;
          clr_o   = 1'b1;
        end
      end
      WS_ERASE: begin
        if (err_i) begin
          st_d = WS_FAULT;
        end else if (ok_i) begin
          if (last_i) begin
            st_d = WS_FUSE;
          end else begin
            inc_o   = 1'b1;
            start_o = 1'b1;
          end
        end
      end
      WS_FUSE:  if (fuse_ack_i) st_d = WS_DONE;
      WS_DONE:  st_d = WS_DONE;
      WS_FAULT: st_d = WS_FAULT;
      default:  st_d = WS_FAULT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WS_IDLE;
    else        st_q <= st_d;
  end

  assign fuse_req_o = (st_q == WS_FUSE);
  assign busy_o     = (st_q == WS_ERASE) || (st_q == WS_FUSE);
  assign done_o     = (st_q == WS_DONE);
  assign fault_o    = (st_q == WS_FAULT);
  assign complete_o = (st_q == WS_DONE) && wipe_fuse_i;

  // R7: fault is sticky until reset
  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> fault_o);

  // R4: done is sticky until reset
  p_done_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

  // R4: the fuse request holds until acknowledged
  p_fuse_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_req_o && !fuse_ack_i) |=> fuse_req_o);

  // R4: the fuse acknowledge leads to done
  p_fuse_to_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_req_o && fuse_ack_i) |=> done_o);

  // R7: an error response lands in fault
  p_err_to_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_i |=> fault_o);
endmodule

// File: rtl/rma_wipe_seq.sv
module rma_wipe_seq #(
  parameter int N_REGIONS = 3,
  parameter int REG_W     = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rma_lc_i,
  input  logic             wipe_fuse_i,
  output logic             erase_req_valid,
  input  logic             erase_req_ready,
  output logic [REG_W-1:0] erase_req_region,
  input  logic             erase_ack_valid,
  input  logic             erase_ack_err,
  output logic             fuse_prog_req,
  input  logic             fuse_prog_ack,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic             wipe_complete
);
  logic             start_w, clr_w, inc_w, ok_w, err_w, last_w;
  logic [REG_W-1:0] idx_w;

  rma_wipe_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rma_lc_i   (rma_lc_i),
    .wipe_fuse_i(wipe_fuse_i),
    .ok_i       (ok_w),
    .err_i      (err_w),
    .last_i     (last_w),
    .fuse_ack_i (fuse_prog_ack),
    .start_o    (start_w),
    .clr_o      (clr_w),
    .inc_o      (inc_w),
    .fuse_req_o (fuse_prog_req),
    .busy_o     (busy),
    .done_o     (done),
    .fault_o    (fault),
    .complete_o (wipe_complete)
  );

  rma_region_ctr #(.N_REGIONS(N_REGIONS), .REG_W(REG_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr_w),
    .inc_i (inc_w),
    .idx_o (idx_w),
    .last_o(last_w)
  );

  rma_erase_issuer #(.REG_W(REG_W)) u_issue (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_w),
    .region_i    (idx_w),
    .req_valid_o (erase_req_valid),
    .req_region_o(erase_req_region),
    .req_ready_i (erase_req_ready),
    .ack_valid_i (erase_ack_valid),
    .ack_err_i   (erase_ack_err),
    .ok_o        (ok_w),
    .err_o       (err_w)
  );

  // R6: the debug qualifier never overlaps busy or fault
  p_complete_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_complete |-> (!busy && !fault && !erase_req_valid && !fuse_prog_req));

  // R7: no erase request is raised once faulted
  p_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !erase_req_valid);

  // R10: a raised erase request implies busy
  p_req_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req_valid |-> busy);

  // R5: done never coexists with an erase or fuse request
  p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!erase_req_valid && !fuse_prog_req));
endmodule

// File: tb/rma_wipe_seq_test.sv
module rma_wipe_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rma_lc_i = 1'b0, wipe_fuse_i = 1'b0;
  logic       erase_req_valid, erase_req_ready = 1'b0;
  logic [1:0] erase_req_region;
  logic       erase_ack_valid = 1'b0, erase_ack_err = 1'b0;
  logic       fuse_prog_req, fuse_prog_ack = 1'b0;
  logic       busy, done, fault, wipe_complete;

  int n_vec = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  rma_wipe_seq uut (
    .clk(clk), .rst_n(rst_n), .rma_lc_i(rma_lc_i), .wipe_fuse_i(wipe_fuse_i),
    .erase_req_valid(erase_req_valid), .erase_req_ready(erase_req_ready),
    .erase_req_region(erase_req_region), .erase_ack_valid(erase_ack_valid),
    .erase_ack_err(erase_ack_err), .fuse_prog_req(fuse_prog_req),
    .fuse_prog_ack(fuse_prog_ack), .busy(busy), .done(done), .fault(fault),
    .wipe_complete(wipe_complete)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual cycles=%0d expected finish", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    n_vec++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rnd(input int lim);
    return int'($urandom % lim);
  endfunction

  task automatic do_reset(input bit fuse, input bit lc);
    @(negedge clk);
    rst_n = 1'b0; wipe_fuse_i = fuse; rma_lc_i = lc;
    erase_req_ready = 0; erase_ack_valid = 0; erase_ack_err = 0; fuse_prog_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_req(output bit seen);
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      if (erase_req_valid) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  // one region: check code, stall, accept, answer
  task automatic erase_one(input int exp_reg, input bit err, input string tag);
    bit seen;
    wait_req(seen);
    chk(seen, tag, int'(seen), 1);
    chk(erase_req_region == 2'(exp_reg), tag, int'(erase_req_region), exp_reg);
    chk(busy, "R10 busy during request", int'(busy), 1);
    for (int s = rnd(4); s > 0; s--) begin
      @(negedge clk);
      chk(erase_req_valid && erase_req_region == 2'(exp_reg), "R3 stall hold",
          int'(erase_req_region), exp_reg);
    end
    erase_req_ready = 1;
    @(negedge clk);
    erase_req_ready = 0;
    chk(!erase_req_valid, "R2 single outstanding", int'(erase_req_valid), 0);
    for (int s = rnd(4); s > 0; s--) begin
      @(negedge clk);
      chk(!erase_req_valid, "R2 wait for ack", int'(erase_req_valid), 0);
    end
    erase_ack_valid = 1; erase_ack_err = err;
    @(negedge clk);
    erase_ack_valid = 0; erase_ack_err = 0;
  endtask

  task automatic finish_fuse();
    bit seen = 0;
    for (int i = 0; i < 50; i++) begin
      if (fuse_prog_req) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(seen, "R4 fuse request", int'(seen), 1);
    chk(busy && !wipe_complete && !done, "R6 no complete before fuse",
        int'(wipe_complete), 0);
    for (int s = rnd(5); s > 0; s--) begin
      @(negedge clk);
      chk(fuse_prog_req, "R4 fuse request hold", int'(fuse_prog_req), 1);
    end
    fuse_prog_ack = 1;
    @(negedge clk);
    fuse_prog_ack = 0; wipe_fuse_i = 1;
    #1;
    chk(done, "R4 done after fuse ack", int'(done), 1);
    chk(wipe_complete, "R6 complete with fuse", int'(wipe_complete), 1);
    chk(!busy && !fault, "R10 busy cleared", int'(busy), 0);
    repeat (3) @(negedge clk);
    chk(done && wipe_complete, "R4 done sticky", int'(done), 1);
  endtask

  task automatic full_wipe();
    erase_one(0, 0, "R1 first region");
    erase_one(1, 0, "R2 region order");
    erase_one(2, 0, "R2 region order");
    finish_fuse();
  endtask

  initial begin
    int cnt;
    bit seen;
    void'($urandom(32'd2718));

    // R9: idle with lifecycle and fuse clear
    do_reset(0, 0);
    for (int i = 0; i < 8; i++) begin
      chk(!erase_req_valid && !fuse_prog_req && !busy && !done && !fault && !wipe_complete,
          "R9 idle quiet", int'({erase_req_valid, busy, done, fault}), 0);
      @(negedge clk);
    end

    // R1 then full flow, several random runs
    for (int k = 0; k < 5; k++) begin
      do_reset(0, 1);
      full_wipe();
    end

    // R1: lifecycle bit programmed later starts erasure automatically
    do_reset(0, 0);
    repeat (4) @(negedge clk);
    chk(!erase_req_valid, "R9 no start without lifecycle", int'(erase_req_valid), 0);
    rma_lc_i = 1;
    full_wipe();

    // R5: pre-burnt fuse
    do_reset(1, 1);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      if (erase_req_valid || fuse_prog_req || busy) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0, "R5 no requests with fuse set", cnt, 0);
    chk(done && wipe_complete, "R5 done with fuse set", int'(wipe_complete), 1);

    // R7: error on a random region
    for (int k = 0; k < 3; k++) begin
      int bad = rnd(3);
      do_reset(0, 1);
      for (int r = 0; r <= bad; r++) erase_one(r, r == bad, "R2 region order");
      cnt = 0;
      for (int i = 0; i < 20; i++) begin
        if (erase_req_valid || fuse_prog_req || wipe_complete || !fault) cnt++;
        @(negedge clk);
      end
      chk(cnt == 0, "R7 fault sticky and quiet", cnt, 0);
      chk(!done && !busy, "R7 not done", int'(done), 0);
    end

    // R8: reset between regions restarts from region 0
    do_reset(0, 1);
    erase_one(0, 0, "R1 first region");
    wait_req(seen);
    chk(seen && erase_req_region == 2'd1, "R2 second region", int'(erase_req_region), 1);
    do_reset(0, 1);
    erase_one(0, 0, "R8 restart at region 0");
    erase_one(1, 0, "R8 order after restart");
    erase_one(2, 0, "R8 order after restart");
    finish_fuse();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule